// File: doc/BRIEF.md
# Ethernet PHY management start-up sequencer

This block brings an Ethernet PHY into a known speed and duplex setting right after power-up. It uses only the two-wire management interface: a divided clock (MDC) and a bidirectional data line (MDIO). The data line is presented as three split signals: output value, output enable and input. The pad or the board supplies the pull-up.

A small table of eight 32-bit management words is addressed by a latched rate-select bit and a two-bit step index. A controller walks the three steps of one attempt:
- a control-register write that sets the PHY's self-clearing reset bit;
- a control-register write of the wanted configuration;
- a control-register read.

A shift engine sends each word behind a preamble of ones. For a read it releases the line at turnaround and shifts the register contents in. An idle gap separates consecutive transfers.

If the value read back equals the configuration, the block raises and holds a done flag that releases downstream clock and reset logic. Otherwise it lights an error flag, counts a retry and starts a new attempt from the first step.

Top module: `mdio_phy_init`

## Requirements
- R1: `mdc` runs at the system clock divided by 2*HALF_DIV with equal high and low times of HALF_DIV cycles each. The default HALF_DIV = 3 gives 20.8 MHz from 125 MHz, inside the 25 MHz limit.
- R2: Each transfer on the line is 64 MDC bits, most significant first. The first 32 bits are preamble ones. The rest are start `01`, opcode (write `01`, read `10`), 5-bit PHY address PHY_ADDR, 5-bit register address 0, turnaround `10`, and 16 data bits.
- R3: One attempt is three transfers:
  - write 16'h8000 (bit 15, self-clearing reset);
  - write the configuration;
  - read.

  The configuration is CFG_100 (default 16'h2100: bit 13 speed, bit 8 full duplex) when `rate_10m_sel` is 0, and CFG_10 (default 16'h0100) when it is 1. `rate_10m_sel` is sampled once at the start of each attempt.
- R4: `mdio_o` changes only on the clock edge on which `mdc` falls. Read data is sampled on rising MDC edges.
- R5: `mdio_oe` is high through a whole write transfer and through bits 0 to 45 of a read transfer. It is low for the read turnaround and data bits, and whenever no transfer runs.
- R6: Between the last bit of one transfer and the first preamble bit of the next there are GAP_MDC or GAP_MDC+1 rising MDC edges with the line released.
- R7: A read-back equal to the configuration sets `init_done`, clears `init_error`, and ends all line activity. `init_done` then holds until reset.
- R8: A read-back that differs sets `init_error` and increments `retry_count` (saturating). The full three-step sequence then repeats from the reset write.
- R9: During and right after reset: `mdc`=0, `mdio_o`=1, `mdio_oe`=0, `init_done`=0, `init_error`=0, `retry_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_10m_sel | input | 1 | 0 selects 100 Mb/s configuration, 1 selects 10 Mb/s |
| mdio_i | input | 1 | Level seen on the management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Drive enable for the data line |
| init_done | output | 1 | PHY configured and verified, held |
| init_error | output | 1 | Last verification failed; lit during retries |
| retry_count | output | RETRY_W | Number of failed verifications, saturating |

## Verification
The bench models the PHY at the line level. It decodes every transfer and answers reads, and can corrupt a chosen number of read-backs. It therefore checks:
- the exact sequence of words per attempt;
- the drive-enable pattern around turnaround, where a design that kept driving would collide with the PHY's answer;
- the idle gap between transfers, where a missing gap shows up as too few released edges.

Corrupted read-backs must leave done low, light the error flag and bump the retry count once per failure. A design that compared the wrong word or restarted mid-sequence would emit a wrong frame list.

The rate input is flipped in the middle of a failing attempt. A design that did not latch it would mix configurations within one attempt.

// File: rtl/mdio_init_pkg.sv
package mdio_init_pkg;

  typedef enum logic [2:0] {
    SEQ_GAP,
    SEQ_START,
    SEQ_WAIT,
    SEQ_CHECK,
    SEQ_DONE
  } seq_state_t;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam int unsigned FRAME_BITS  = 64;
  localparam int unsigned PRE_BITS    = 32;
  localparam int unsigned RD_DRIVE    = 46;
  localparam int unsigned RD_DATA_LO  = 48;

  localparam logic [1:0] STEP_RESET = 2'd0;
  localparam logic [1:0] STEP_PROG  = 2'd1;
  localparam logic [1:0] STEP_CHECK = 2'd2;

  function automatic logic [31:0] mgmt_word(input logic [1:0] op,
                                            input logic [4:0] phy,
                                            input logic [4:0] regad,
                                            input logic [15:0] data);
    logic [1:0] ta;
    ta = (op == OP_WRITE) ? 2'b10 : 2'b11;
    return {2'b01, op, phy, regad, ta, data};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int unsigned CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = wrap & ~mdc_q;
  assign fall_stb = wrap & mdc_q;

endmodule

// File: rtl/mdio_frame_rom.sv
module mdio_frame_rom
  import mdio_init_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR = 5'd1,
  parameter logic [15:0] CFG_100  = 16'h2100,
  parameter logic [15:0] CFG_10   = 16'h0100
) (
  input  logic [2:0]  addr,
  output logic [31:0] word,
  output logic [15:0] cfg_value
);

  localparam logic [4:0]  CTRL_REG  = 5'd0;
  localparam logic [15:0] RESET_VAL = 16'h8000;

  logic [15:0] cfg_sel;

  assign cfg_sel   = addr[2] ? CFG_10 : CFG_100;
  assign cfg_value = cfg_sel;

  always_comb begin
    case (addr[1:0])
      STEP_RESET: word = mgmt_word(OP_WRITE, PHY_ADDR, CTRL_REG, RESET_VAL);
      STEP_PROG:  word = mgmt_word(OP_WRITE, PHY_ADDR, CTRL_REG, cfg_sel);
      STEP_CHECK: word = mgmt_word(OP_READ,  PHY_ADDR, CTRL_REG, 16'h0000);
      default:    word = '1;
    endcase
  end

endmodule

// File: rtl/mdio_shift_port.sv
module mdio_shift_port
  import mdio_init_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        start,
  input  logic [31:0] word,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata
);

  logic        run_q, run_d;
  logic        arm_q, arm_d;
  logic [5:0]  bit_q, bit_d;
  logic [31:0] word_q, word_d;
  logic        o_q, o_d;
  logic        oe_q, oe_d;
  logic        done_q, done_d;
  logic [15:0] rd_q, rd_d;
  logic        is_read;
  logic [5:0]  nb;
  logic [5:0]  wi;

  assign is_read = (word_q[29:28] == OP_READ);

  always_comb begin
    run_d  = run_q;
    arm_d  = arm_q;
    bit_d  = bit_q;
    word_d = word_q;
    o_d    = o_q;
    oe_d   = oe_q;
    done_d = 1'b0;
    rd_d   = rd_q;
    nb     = bit_q + 6'd1;
    wi     = 6'd63 - nb;
    if (!run_q) begin
      if (start && !arm_q) begin
        arm_d  = 1'b1;
        word_d = word;
      end
      if (arm_q && fall_stb) begin
        run_d = 1'b1;
        arm_d = 1'b0;
        bit_d = '0;
        o_d   = 1'b1;
        oe_d  = 1'b1;
        rd_d  = '0;
      end
    end else begin
      if (fall_stb) begin
        if (bit_q == 6'(FRAME_BITS - 1)) begin
          run_d  = 1'b0;
          done_d = 1'b1;
          o_d    = 1'b1;
          oe_d   = 1'b0;
        end else begin
          bit_d = nb;
          o_d   = (nb < 6'(PRE_BITS)) ? 1'b1 : word_q[wi[4:0]];
          oe_d  = !is_read || (nb < 6'(RD_DRIVE));
        end
      end
      if (rise_stb && is_read && (bit_q >= 6'(RD_DATA_LO))) begin
        rd_d = {rd_q[14:0], mdio_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      bit_q  <= '0;
      word_q <= '0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      run_q  <= run_d;
      arm_q  <= arm_d;
      bit_q  <= bit_d;
      word_q <= word_d;
      o_q    <= o_d;
      oe_q   <= oe_d;
      done_q <= done_d;
      rd_q   <= rd_d;
    end
  end

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign busy    = run_q | arm_q;
  assign done    = done_q;
  assign rdata   = rd_q;

  // R5: a read transfer never drives during its final data bit
  a_r5_read_tail_released: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && is_read && (bit_q == 6'd63)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_init_pkg::*;
#(
  parameter int unsigned GAP_MDC = 8,
  parameter int unsigned RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rate_sel,
  input  logic               rise_stb,
  input  logic               eng_busy,
  input  logic               eng_done,
  input  logic [15:0]        rdata,
  input  logic [15:0]        cfg_value,
  output logic [2:0]         rom_addr,
  output logic               start,
  output logic               init_done,
  output logic               init_error,
  output logic [RETRY_W-1:0] retry_count
);

  localparam int unsigned GW = $clog2(GAP_MDC + 1);

  seq_state_t         st_q, st_d;
  logic [1:0]         idx_q, idx_d;
  logic               rate_q, rate_d;
  logic [GW-1:0]      gap_q, gap_d;
  logic               done_q, done_d;
  logic               err_q, err_d;
  logic [RETRY_W-1:0] rty_q, rty_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    rate_d = rate_q;
    gap_d  = gap_q;
    done_d = done_q;
    err_d  = err_q;
    rty_d  = rty_q;
    start  = 1'b0;
    case (st_q)
      SEQ_GAP: begin
        if (rise_stb) begin
          if (gap_q == GW'(GAP_MDC - 1)) begin
            st_d  = SEQ_START;
            gap_d = '0;
            if (idx_q == STEP_RESET) begin
              rate_d = rate_sel;
            end
          end else begin
            gap_d = gap_q + 1'b1;
          end
        end
      end
      SEQ_START: begin
        start = 1'b1;
        st_d  = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (eng_done) begin
          if (idx_q == STEP_CHECK) begin
            st_d = SEQ_CHECK;
          end else begin
            idx_d = idx_q + 2'd1;
            gap_d = '0;
            st_d  = SEQ_GAP;
          end
        end
      end
      SEQ_CHECK: begin
        if (rdata == cfg_value) begin
          done_d = 1'b1;
          err_d  = 1'b0;
          st_d   = SEQ_DONE;
        end else begin
          err_d = 1'b1;
          if (rty_q != '1) begin
            rty_d = rty_q + 1'b1;
          end
          idx_d = STEP_RESET;
          gap_d = '0;
          st_d  = SEQ_GAP;
        end
      end
      SEQ_DONE: begin
        st_d = SEQ_DONE;
      end
      default: begin
        st_d = SEQ_GAP;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_GAP;
      idx_q  <= STEP_RESET;
      rate_q <= 1'b0;
      gap_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rty_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      rate_q <= rate_d;
      gap_q  <= gap_d;
      done_q <= done_d;
      err_q  <= err_d;
      rty_q  <= rty_d;
    end
  end

  assign rom_addr    = {rate_q, idx_q};
  assign init_done   = done_q;
  assign init_error  = err_q;
  assign retry_count = rty_q;

  // R6: a new transfer is only requested while the engine is idle
  a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !eng_busy);

  // R7: done is held once reached
  a_r7_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7: done and error are never lit together
  a_r7_done_clears_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_error));

  // R8: the retry count only moves together with a lit error
  a_r8_retry_with_error: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_count != $past(retry_count)) |-> init_error);

endmodule

// File: rtl/mdio_phy_init.sv
module mdio_phy_init
  import mdio_init_pkg::*;
#(
  parameter int unsigned HALF_DIV = 3,
  parameter int unsigned GAP_MDC  = 8,
  parameter int unsigned RETRY_W  = 4,
  parameter logic [4:0]  PHY_ADDR = 5'd1,
  parameter logic [15:0] CFG_100  = 16'h2100,
  parameter logic [15:0] CFG_10   = 16'h0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rate_10m_sel,
  input  logic               mdio_i,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               init_done,
  output logic               init_error,
  output logic [RETRY_W-1:0] retry_count
);

  logic [1:0]  rst_sync_q;
  logic        rst_n_int;
  logic        rise_stb;
  logic        fall_stb;
  logic [2:0]  rom_addr;
  logic [31:0] rom_word;
  logic [15:0] cfg_value;
  logic        eng_start;
  logic        eng_busy;
  logic        eng_done;
  logic [15:0] eng_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[1];

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_rom #(.PHY_ADDR(PHY_ADDR), .CFG_100(CFG_100), .CFG_10(CFG_10)) u_rom (
    .addr      (rom_addr),
    .word      (rom_word),
    .cfg_value (cfg_value)
  );

  mdio_shift_port u_port (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .start    (eng_start),
    .word     (rom_word),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (eng_busy),
    .done     (eng_done),
    .rdata    (eng_rdata)
  );

  mdio_seq_ctrl #(.GAP_MDC(GAP_MDC), .RETRY_W(RETRY_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .rate_sel    (rate_10m_sel),
    .rise_stb    (rise_stb),
    .eng_busy    (eng_busy),
    .eng_done    (eng_done),
    .rdata       (eng_rdata),
    .cfg_value   (cfg_value),
    .rom_addr    (rom_addr),
    .start       (eng_start),
    .init_done   (init_done),
    .init_error  (init_error),
    .retry_count (retry_count)
  );

  // R4: the data output only moves together with a falling MDC
  a_r4_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(mdio_o) |-> $fell(mdc));

  // R7: after done the line is left released
  a_r7_released_after_done: assert property (@(posedge clk) disable iff (!rst_n_int)
    init_done |-> !mdio_oe);

  // R1: MDC never toggles on two consecutive clock edges
  a_r1_no_double_toggle: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(mdc) |=> $stable(mdc));

endmodule

// File: tb/sim_mdio_phy_init.sv
module sim_mdio_phy_init;

  localparam int HALF_DIV = 3;
  localparam int GAP_MDC  = 8;
  localparam int RETRY_W  = 4;
  localparam logic [15:0] CFG_100 = 16'h2100;
  localparam logic [15:0] CFG_10  = 16'h0100;

  logic clk;
  logic rst_n;
  logic rate_10m_sel;
  logic mdio_i;
  logic mdc, mdio_o, mdio_oe, init_done, init_error;
  logic [RETRY_W-1:0] retry_count;

  int n_chk;
  int n_fail;
  int cycles;

  mdio_phy_init #(.HALF_DIV(HALF_DIV), .GAP_MDC(GAP_MDC), .RETRY_W(RETRY_W),
                  .PHY_ADDR(5'd1), .CFG_100(CFG_100), .CFG_10(CFG_10)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_10m_sel(rate_10m_sel), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .init_done(init_done),
    .init_error(init_error), .retry_count(retry_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural PHY on the line ----------------
  logic        phy_out;
  int          ones;
  bit          in_frame;
  int          k;
  logic [29:0] sr;
  bit          fr_read;
  logic [15:0] reg_val;
  int          corrupt_left;
  bit          resp_on;
  int          resp_idx;
  logic [15:0] resp_data;
  bit          counting_gap;
  int          gap_cnt;
  logic [31:0] frames[$];
  bit          err_seen;

  assign mdio_i = mdio_oe ? mdio_o : phy_out;

  always @(posedge mdc) begin
    if (!in_frame) begin
      if (counting_gap) begin
        if (!mdio_oe) gap_cnt++;
        else begin
          counting_gap = 0;
          chk(gap_cnt >= GAP_MDC && gap_cnt <= GAP_MDC + 1, "R6 gap", gap_cnt, GAP_MDC);
        end
      end
      if (mdio_i) ones++;
      else begin
        if (ones >= 32) begin in_frame = 1; k = -1; end
        ones = 0;
      end
    end else if (k == -1) begin
      chk(mdio_i == 1'b1, "R2 start bit", mdio_i, 1);
      k = 0;
    end else begin
      sr = {sr[28:0], mdio_i};
      if (k == 1) fr_read = (sr[1:0] == 2'b10);
      if (k >= 2) chk(mdio_oe == ((fr_read && k >= 12) ? 1'b0 : 1'b1), "R5 drive enable",
                      mdio_oe, (fr_read && k >= 12) ? 0 : 1);
      if (k == 11 && fr_read) begin
        resp_on  = 1; resp_idx = 0;
        resp_data = (corrupt_left > 0) ? (reg_val ^ 16'h0001) : reg_val;
        if (corrupt_left > 0) corrupt_left--;
      end
      if (k == 29) begin
        in_frame = 0; ones = 0;
        frames.push_back({2'b01, sr});
        if (!fr_read) reg_val = sr[15:0] & 16'h7fff;
        counting_gap = 1; gap_cnt = 0;
      end else k++;
    end
  end

  always @(negedge mdc) begin
    if (resp_on) begin
      if (resp_idx == 0) phy_out = 1'b1;
      else if (resp_idx == 1) phy_out = 1'b0;
      else if (resp_idx < 18) phy_out = resp_data[17 - resp_idx];
      else begin phy_out = 1'b1; resp_on = 0; end
      resp_idx++;
    end
  end

  // ---------------- per-clock reference checks ----------------
  logic mdc_prev, o_prev;
  int   since_edge;
  bit   seen_edge;

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      seen_edge = 0; since_edge = 0; mdc_prev = mdc; o_prev = mdio_o;
    end else begin
      since_edge++;
      if (mdc !== mdc_prev) begin
        if (seen_edge) chk(since_edge == HALF_DIV, "R1 half period", since_edge, HALF_DIV);
        seen_edge = 1; since_edge = 0;
      end
      if (mdio_o !== o_prev)
        chk(mdc_prev == 1'b1 && mdc == 1'b0, "R4 output moves on falling MDC", mdc, 0);
      if (init_error && !init_done) err_seen = 1;
      mdc_prev = mdc; o_prev = mdio_o;
    end
    if (cycles > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] wr_word(input logic [15:0] d);
    return {2'b01, 2'b01, 5'd1, 5'd0, 2'b10, d};
  endfunction
  function automatic logic [31:0] rd_word(input logic [15:0] d);
    return {2'b01, 2'b10, 5'd1, 5'd0, 2'b10, d};
  endfunction

  task automatic run(input bit rate0, input bit rate1, input int corrupt);
    int n;
    logic [15:0] cfg;
    logic [31:0] exp_w;
    rst_n = 1'b0;
    rate_10m_sel = rate0;
    corrupt_left = corrupt;
    frames.delete();
    in_frame = 0; ones = 0; resp_on = 0; phy_out = 1'b1;
    counting_gap = 0; reg_val = 16'h1000; err_seen = 0;
    repeat (5) @(negedge clk);
    chk(mdc == 1'b0 && mdio_o == 1'b1 && mdio_oe == 1'b0, "R9 line idle in reset",
        {mdc, mdio_o, mdio_oe}, 3'b010);
    chk(init_done == 0 && init_error == 0 && retry_count == 0, "R9 flags in reset",
        {init_done, init_error, retry_count}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(init_done == 0 && init_error == 0 && retry_count == 0 && mdio_oe == 0,
        "R9 state after release", {init_done, init_error, retry_count}, 0);
    n = 0;
    while (!init_done && n < 30000) begin
      @(negedge clk);
      n++;
      if (frames.size() >= 1) rate_10m_sel = rate1;
    end
    chk(init_done == 1'b1, "R7 done reached", init_done, 1);
    chk(init_error == 1'b0, "R7 error cleared on success", init_error, 0);
    chk(err_seen == (corrupt > 0), "R8 error lit during retry", err_seen, corrupt > 0);
    chk(retry_count == corrupt, "R8 retry count", retry_count, corrupt);
    chk(frames.size() == 3 * (corrupt + 1), "R3 transfer count", frames.size(), 3 * (corrupt + 1));
    for (int a = 0; a <= corrupt; a++) begin
      cfg = ((a == 0) ? rate0 : rate1) ? CFG_10 : CFG_100;
      if (frames.size() >= 3 * a + 3) begin
        chk(frames[3*a] == wr_word(16'h8000), "R2 R3 reset write word", frames[3*a], wr_word(16'h8000));
        chk(frames[3*a+1] == wr_word(cfg), "R3 config write word", frames[3*a+1], wr_word(cfg));
        exp_w = rd_word((a < corrupt) ? (cfg ^ 16'h0001) : cfg);
        chk(frames[3*a+2] == exp_w, "R2 R3 read word", frames[3*a+2], exp_w);
      end
    end
    n = frames.size();
    repeat (2000) @(negedge clk);
    chk(frames.size() == n && init_done == 1 && mdio_oe == 0, "R7 quiet and held after done",
        frames.size(), n);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cycles = 0;
    rst_n = 1'b0; rate_10m_sel = 1'b0; phy_out = 1'b1;
    run(1'b0, 1'b0, 0);
    run(1'b1, 1'b1, 0);
    run(1'b1, 1'b0, 1);
    run(1'b0, 1'b0, 3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule